// File: doc/BRIEF.md
# Matrix Multiply Element-Index Sequencer

This block drives a loop of scalar multiply-add operations that together multiply two matrices held as flat element arrays. It is configured with three dimensions: the number of result columns, the number of result rows, and the inner dimension that the two operands share. It then hands out one step per accepted handshake. Each step carries three flattened element offsets: one into the left operand, one into the right operand, and one into the accumulator/result array. Every matrix is laid out row by row.

Steps follow inner-product order. The result-column counter moves fastest, the result-row counter moves next, and the inner-dimension counter moves slowest. As a result, the accumulator offset changes on every step, so a multiply-add never has to wait for the one just before it. The block also reports the total step count, one end flag per counter, and a last-step flag. It pulses done once the final step has been accepted. A configuration that has a zero dimension, or a total above 127 steps, is refused with an error flag, and no steps are issued for it.

Top module: `mm_sched_gen`

## Requirements
- R1: One cycle after `start_i` with a legal configuration, `valid_o` is 1, `err_o` is 0, `vl_o` equals cols×rows×inner, and all three offsets are 0.
- R2: The counters step in this order. Column counter x goes 0..cols−1 on every accepted step. Row counter y advances when x wraps. Inner counter z advances when y wraps. For cols=2, rows=2, inner=3 the left offsets are 0,0,3,3,1,1,4,4,2,2,5,5 and the right offsets are 0,1,0,1,2,3,2,3,4,5,4,5.
- R3: The offsets are left = y·inner+z, right = z·cols+x, and accumulator = y·cols+x. Each is 7 bits wide and is always below `vl_o` while valid.
- R4: If the product of the three dimensions exceeds 127, the cycle after start has `err_o`=1, `valid_o`=0 and `vl_o`=0.
- R5: A configuration with any dimension equal to 0 is refused in the same way as R4.
- R6: While `valid_o`=1 and `ready_i`=0, `valid_o` stays 1 and all offsets and flags hold their values.
- R7: `end_o` bit 0 is x==cols−1, bit 1 is y==rows−1, and bit 2 is z==inner−1. `last_o` is 1 on exactly the one step where all three bits are 1.
- R8: After the last step is accepted, `valid_o` is 0 and `done_o` is 1 for exactly one cycle.
- R9: When cols×rows>1, two consecutively accepted steps never carry the same accumulator offset.
- R10: A `start_i` during a run abandons that run. On the next cycle the block shows step 0 of the new configuration, and start takes precedence over a handshake in the same cycle.
- R11: After reset, `valid_o`, `done_o`, `err_o` and `vl_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load dimensions and restart the schedule |
| n_col_i | input | 7 | Result columns (columns of right operand) |
| n_row_i | input | 7 | Result rows (rows of left operand) |
| n_inner_i | input | 7 | Shared inner dimension |
| ready_i | input | 1 | Consumer accepts the current step |
| valid_o | output | 1 | A step is presented |
| src1_off_o | output | 7 | Left operand element offset |
| src2_off_o | output | 7 | Right operand element offset |
| acc_off_o | output | 7 | Accumulator/result element offset |
| end_o | output | 3 | Per-counter end flags {inner, row, col} |
| last_o | output | 1 | Current step is the final one |
| vl_o | output | 7 | Total step count of the loaded configuration |
| err_o | output | 1 | Loaded configuration was refused |
| done_o | output | 1 | One-cycle pulse after the last step is accepted |

## Verification
Two functions can fall in the same cycle. The first pair is a restart pulse and an accepted handshake. The bench raises `start_i` while `ready_i` is high in the middle of a held run, and checks that the next cycle shows step 0 of the new dimensions rather than an advanced old step. The second pair is the final handshake and the done pulse. Every table run checks that valid falls in the same cycle that done rises, and that done is low again one cycle later.

// File: rtl/mm_sched_pkg.sv
package mm_sched_pkg;

    localparam int unsigned DIM_W  = 7;
    localparam int unsigned IDX_W  = 7;
    localparam int unsigned N_AXIS = 3;
    localparam int unsigned MAX_VL = 127;
    localparam int unsigned PROD_W = N_AXIS * DIM_W;

    typedef struct packed {
        logic [DIM_W-1:0] cols;
        logic [DIM_W-1:0] rows;
        logic [DIM_W-1:0] inner;
        logic [IDX_W-1:0] vl;
        logic             active;
        logic             err;
        logic             done;
    } ctl_t;

endpackage

// File: rtl/mm_dim_check.sv
module mm_dim_check
    import mm_sched_pkg::*;
(
    input  logic [DIM_W-1:0] cols_i,
    input  logic [DIM_W-1:0] rows_i,
    input  logic [DIM_W-1:0] inner_i,
    output logic             ok_o,
    output logic [IDX_W-1:0] vl_o
);

    logic [PROD_W-1:0] prod_w;
    logic              nonzero_w;

    assign prod_w    = PROD_W'(cols_i) * PROD_W'(rows_i) * PROD_W'(inner_i);
    assign nonzero_w = (cols_i != '0) && (rows_i != '0) && (inner_i != '0);
    assign ok_o      = nonzero_w && (prod_w <= PROD_W'(MAX_VL));
    assign vl_o      = ok_o ? prod_w[IDX_W-1:0] : '0;

endmodule

// File: rtl/mm_step_ctr.sv
module mm_step_ctr
    import mm_sched_pkg::*;
(
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           clear_i,
    input  logic                           adv_i,
    input  logic [N_AXIS-1:0][DIM_W-1:0]   lim_i,
    output logic [N_AXIS-1:0][DIM_W-1:0]   cnt_o,
    output logic [N_AXIS-1:0]              end_o
);

    logic [N_AXIS-1:0][DIM_W-1:0] cnt_d, cnt_q;
    logic [N_AXIS:0]              carry_w;
    logic [N_AXIS-1:0]            end_w;

    assign carry_w[0] = adv_i;

    // axis 0 is fastest; each wrap carries into the next slower axis
    for (genvar k = 0; k < N_AXIS; k++) begin : g_axis
        assign end_w[k]     = (cnt_q[k] == lim_i[k] - DIM_W'(1));
        assign carry_w[k+1] = carry_w[k] & end_w[k];
        assign cnt_d[k]     = clear_i    ? '0 :
                              carry_w[k] ? (end_w[k] ? '0 : cnt_q[k] + DIM_W'(1)) :
                                           cnt_q[k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
    assign end_o = end_w;

    // R2: column counter steps by one when it is not at its end
    a_r2_col_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i && !clear_i && !end_w[0] |=> cnt_q[0] == $past(cnt_q[0]) + DIM_W'(1));

    // R2: row counter waits while the column counter has not wrapped
    a_r2_row_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i && !clear_i && !end_w[0] |=> $stable(cnt_q[1]));

endmodule

// File: rtl/mm_flat_addr.sv
module mm_flat_addr
    import mm_sched_pkg::*;
(
    input  logic [DIM_W-1:0] x_i,
    input  logic [DIM_W-1:0] y_i,
    input  logic [DIM_W-1:0] z_i,
    input  logic [DIM_W-1:0] cols_i,
    input  logic [DIM_W-1:0] inner_i,
    output logic [IDX_W-1:0] src1_o,
    output logic [IDX_W-1:0] src2_o,
    output logic [IDX_W-1:0] acc_o
);

    localparam int unsigned WIDE_W = 2 * DIM_W + 1;

    // row-major flattening: row * row_length + column
    assign src1_o = IDX_W'(WIDE_W'(y_i) * WIDE_W'(inner_i) + WIDE_W'(z_i));
    assign src2_o = IDX_W'(WIDE_W'(z_i) * WIDE_W'(cols_i)  + WIDE_W'(x_i));
    assign acc_o  = IDX_W'(WIDE_W'(y_i) * WIDE_W'(cols_i)  + WIDE_W'(x_i));

endmodule

// File: rtl/mm_sched_gen.sv
module mm_sched_gen
    import mm_sched_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [DIM_W-1:0] n_col_i,
    input  logic [DIM_W-1:0] n_row_i,
    input  logic [DIM_W-1:0] n_inner_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] src1_off_o,
    output logic [IDX_W-1:0] src2_off_o,
    output logic [IDX_W-1:0] acc_off_o,
    output logic [N_AXIS-1:0] end_o,
    output logic             last_o,
    output logic [IDX_W-1:0] vl_o,
    output logic             err_o,
    output logic             done_o
);

    ctl_t st_d, st_q;

    logic                         cfg_ok_w;
    logic [IDX_W-1:0]             cfg_vl_w;
    logic [N_AXIS-1:0][DIM_W-1:0] cnt_w;
    logic [N_AXIS-1:0]            end_w;
    logic                         fire_w;
    logic                         last_w;

    mm_dim_check i_dim_check (
        .cols_i  (n_col_i),
        .rows_i  (n_row_i),
        .inner_i (n_inner_i),
        .ok_o    (cfg_ok_w),
        .vl_o    (cfg_vl_w)
    );

    assign fire_w = st_q.active & ready_i;
    assign last_w = st_q.active & (&end_w);

    mm_step_ctr i_step_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (start_i),
        .adv_i   (fire_w & ~start_i),
        .lim_i   ({st_q.inner, st_q.rows, st_q.cols}),
        .cnt_o   (cnt_w),
        .end_o   (end_w)
    );

    mm_flat_addr i_flat_addr (
        .x_i     (cnt_w[0]),
        .y_i     (cnt_w[1]),
        .z_i     (cnt_w[2]),
        .cols_i  (st_q.cols),
        .inner_i (st_q.inner),
        .src1_o  (src1_off_o),
        .src2_o  (src2_off_o),
        .acc_o   (acc_off_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.cols   = n_col_i;
            st_d.rows   = n_row_i;
            st_d.inner  = n_inner_i;
            st_d.vl     = cfg_vl_w;
            st_d.err    = ~cfg_ok_w;
            st_d.active = cfg_ok_w;
        end else if (fire_w && last_w) begin
            st_d.active = 1'b0;
            st_d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign valid_o = st_q.active;
    assign end_o   = st_q.active ? end_w : '0;
    assign last_o  = last_w;
    assign vl_o    = st_q.vl;
    assign err_o   = st_q.err;
    assign done_o  = st_q.done;

    // R4: a refused configuration never presents a step
    a_r4_err_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !valid_o);

    // R3: every offset stays inside the step count
    a_r3_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (src1_off_o < vl_o) && (src2_off_o < vl_o) && (acc_off_o < vl_o));

    // R6: a stalled step holds still
    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && !ready_i && !start_i |=> valid_o && $stable(src1_off_o)
            && $stable(src2_off_o) && $stable(acc_off_o) && $stable(last_o));

    // R8: accepting the final step ends the run with a done pulse
    a_r8_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && ready_i && last_o && !start_i |=> done_o && !valid_o);

    // R8: done lasts one cycle
    a_r8_done_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !start_i |=> !done_o);

    // R9: the accumulator target moves on every accepted step
    a_r9_acc_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && ready_i && !last_o && !start_i && (st_q.cols != 1 || st_q.rows != 1)
            |=> acc_off_o != $past(acc_off_o));

endmodule

// File: tb/test_mm_sched_gen.sv
module test_mm_sched_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int N_VEC      = 12;

    // stimulus and expected-result vectors: cols, rows, inner, vl, refused
    localparam int T_COL [N_VEC] = '{2, 1, 3, 1, 127, 2, 0, 4, 5, 3, 7, 1};
    localparam int T_ROW [N_VEC] = '{2, 1, 1, 5, 1,   8, 3, 4, 5, 3, 19, 1};
    localparam int T_INN [N_VEC] = '{3, 1, 4, 2, 1,   8, 3, 4, 5, 0, 1, 127};
    localparam int T_VL  [N_VEC] = '{12, 1, 12, 10, 127, 0, 0, 64, 125, 0, 0, 127};
    localparam int T_ERR [N_VEC] = '{0, 0, 0, 0, 0,   1, 1, 0, 0, 1, 1, 0};

    localparam int REF_S1 [12] = '{0, 0, 3, 3, 1, 1, 4, 4, 2, 2, 5, 5};
    localparam int REF_S2 [12] = '{0, 1, 0, 1, 2, 3, 2, 3, 4, 5, 4, 5};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] n_col = '0;
    logic [6:0] n_row = '0;
    logic [6:0] n_inner = '0;
    logic       ready = 1'b0;
    logic       valid;
    logic [6:0] s1, s2, acc;
    logic [2:0] endf;
    logic       last;
    logic [6:0] vl;
    logic       err;
    logic       done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mm_sched_gen i_mm_sched_gen (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .n_col_i    (n_col),
        .n_row_i    (n_row),
        .n_inner_i  (n_inner),
        .ready_i    (ready),
        .valid_o    (valid),
        .src1_off_o (s1),
        .src2_off_o (s2),
        .acc_off_o  (acc),
        .end_o      (endf),
        .last_o     (last),
        .vl_o       (vl),
        .err_o      (err),
        .done_o     (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp_v);
        chk(act == exp_v, req, act, exp_v);
    endtask

    task automatic load(input int c, input int r, input int k, input bit rdy);
        @(negedge clk);
        n_col = 7'(c); n_row = 7'(r); n_inner = 7'(k);
        start = 1'b1; ready = rdy;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input int c, input int r, input int k, input int evl,
                           input bit eerr, input bit ref_seq);
        int s = 0;
        int prev_acc = -1;
        load(c, r, k, 1'b1);
        chk_eq("R4/R5 err flag", int'(err), int'(eerr));
        chk_eq("R1/R4 vl", int'(vl), evl);
        chk_eq("R1/R4 valid after start", int'(valid), int'(!eerr));
        if (eerr) return;
        for (int z = 0; z < k; z++) begin
            for (int y = 0; y < r; y++) begin
                for (int x = 0; x < c; x++) begin
                    chk_eq("R3 left offset", int'(s1), y * k + z);
                    chk_eq("R3 right offset", int'(s2), z * c + x);
                    chk_eq("R3 acc offset", int'(acc), y * c + x);
                    chk_eq("R7 end flags", int'(endf),
                           {29'd0, z == k - 1, y == r - 1, x == c - 1});
                    chk_eq("R7 last flag", int'(last), int'(s == evl - 1));
                    if (ref_seq) begin
                        chk_eq("R2 left order", int'(s1), REF_S1[s]);
                        chk_eq("R2 right order", int'(s2), REF_S2[s]);
                    end
                    if (s > 0 && c * r > 1)
                        chk(int'(acc) != prev_acc, "R9 acc changes", int'(acc), prev_acc);
                    prev_acc = int'(acc);
                    s++;
                    @(negedge clk);
                end
            end
        end
        chk_eq("R8 valid drops", int'(valid), 0);
        chk_eq("R8 done pulse", int'(done), 1);
        @(negedge clk);
        chk_eq("R8 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R11: reset state
        chk_eq("R11 valid", int'(valid), 0);
        chk_eq("R11 done", int'(done), 0);
        chk_eq("R11 err", int'(err), 0);
        chk_eq("R11 vl", int'(vl), 0);
        rst_n = 1'b1;

        for (int v = 0; v < N_VEC; v++)
            run_vec(T_COL[v], T_ROW[v], T_INN[v], T_VL[v], T_ERR[v] != 0, v == 0);

        // R6: stall in the middle of a run
        load(3, 2, 2, 1'b0);
        chk_eq("R1 step0 acc", int'(acc), 0);
        chk_eq("R6 stalled valid", int'(valid), 1);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        chk_eq("R3 step1 right", int'(s2), 1);
        chk_eq("R3 step1 acc", int'(acc), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_eq("R6 held valid", int'(valid), 1);
            chk_eq("R6 held left", int'(s1), 0);
            chk_eq("R6 held right", int'(s2), 1);
            chk_eq("R6 held acc", int'(acc), 1);
            chk_eq("R6 no done", int'(done), 0);
        end

        // R10: restart with a handshake in the same cycle
        load(2, 1, 1, 1'b1);
        chk_eq("R10 valid", int'(valid), 1);
        chk_eq("R10 vl", int'(vl), 2);
        chk_eq("R10 left", int'(s1), 0);
        chk_eq("R10 right", int'(s2), 0);
        chk_eq("R10 acc", int'(acc), 0);
        chk_eq("R10 last", int'(last), 0);
        @(negedge clk);
        chk_eq("R10 step1 acc", int'(acc), 1);
        chk_eq("R10 step1 last", int'(last), 1);
        @(negedge clk);
        chk_eq("R8 restart done", int'(done), 1);
        chk_eq("R8 restart valid", int'(valid), 0);
        ready = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule